// File: doc/BRIEF.md
# Masked Priority Vector Encoder

This block sits at the end of an interrupt controller's priority path. Each of 64 sources has a raw request line. Software can also raise a request through a per-source force bit. Raw request and force bit together form a pending word. A per-source enable mask then gates that word. Upstream logic hands the block a 128-entry level table: for every priority level, an enable bit and the index of the source that sits at that level. The block picks the lowest-numbered enabled level whose source is pending and unmasked, and it publishes that source's fixed vector number in a registered vector output. An interrupt-request line goes with the vector.

Software can name one source for promotion. While that source is pending and unmasked, it wins over every level in the table. The vector number of a source never depends on its level: source s always reports vector s+1, and vector 0 means nothing is pending. Type classification (normal, management or critical) is left to other logic.

The register port is a plain single-cycle interface. A write takes effect at the clock edge on which `reg_wr` is high. Read data is combinational from `reg_addr`. There is no data stream and no back-pressure: every access completes in the cycle it is presented. The vector output and the interrupt line are recomputed on every clock.

Top module: `prio_vec_enc`

## Requirements
- R1: After reset, `vec_out` is 0, `irq` is 0, and the mask, force and promote registers read 0, so every source is masked.
- R2: The pending word is the raw request OR the force bit for each source. Sources 0..31 read at address 1 and sources 32..63 read at address 2, with bit i of each word standing for source (word base + i).
- R3: A source can produce a vector only when its pending bit is 1 and its mask bit is 1. Mask bits 1 = enabled. Sources 0..31 are at address 3 and sources 32..63 at address 4. A pending source whose mask bit is 0 leaves `vec_out` at 0.
- R4: A force bit set to 1 makes its source request exactly as a raw request would, with the same level and vector. Force words are at addresses 5 (sources 0..31) and 6 (sources 32..63). Writing 0 to a force bit removes the forced request.
- R5: Among levels L = 0..127 with `lvl_en[L]` = 1, the lowest L whose source `lvl_src_flat[L*6 +: 6]` is pending and unmasked selects the vector. A level with `lvl_en[L]` = 0 is ignored.
- R6: The vector for source s is s+1 at whatever level the source sits. Vector 0 means no eligible source.
- R7: The promote register is at address 7, with bit 7 = enable and bits 5:0 = source. While the promote register is enabled and its source is pending and unmasked, that source's vector wins over every level. When that source is not eligible, the promotion has no effect.
- R8: `vec_out` is a register. It reflects the requests, level table and register contents present at the previous clock edge.
- R9: `irq` is 1 exactly when `vec_out` is nonzero.
- R10: The vector is read-only at address 0, reading as `vec_out` zero-extended to 32 bits. Writes to address 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 64 | Raw request line per source |
| lvl_en | input | 128 | Enable bit per priority level |
| lvl_src_flat | input | 768 | Source index per level, level L at bits [L*6 +: 6] |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| vec_out | output | 7 | Registered vector of the winning source, 0 if none |
| irq | output | 1 | Interrupt request, high while the vector is nonzero |

## Verification
Each source pattern is tried twice, first with masks cleared and then with masks set. The difference between the two runs shows that a pending source is held back until it is unmasked. Requests are raised both through raw lines and through force bits, which shows that the two paths give identical vectors. The level table is reshuffled and individual levels are disabled, which separates "vector tracks the source" from "vector tracks the level". A promoted low-priority source is then made eligible and then ineligible, which shows that promotion overrides the table only while the source is eligible. A long random phase compares every cycle against a behavioural model.

// File: rtl/pve_pkg.sv
package pve_pkg;
  localparam int DEF_NSRC  = 64;
  localparam int DEF_NLVL  = 128;
  localparam int DEF_VEC_W = 7;
  localparam int DEF_REG_W = 32;
  localparam int DEF_ADDR_W = 3;

  // bit of the promote register that enables promotion
  localparam int PROM_EN_BIT = 7;

  typedef enum logic [2:0] {
    A_VEC      = 3'd0,
    A_PEND_LO  = 3'd1,
    A_PEND_HI  = 3'd2,
    A_MASK_LO  = 3'd3,
    A_MASK_HI  = 3'd4,
    A_FORCE_LO = 3'd5,
    A_FORCE_HI = 3'd6,
    A_PROMOTE  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/pve_regs.sv
module pve_regs
  import pve_pkg::*;
#(
  parameter int NSRC   = DEF_NSRC,
  parameter int REG_W  = DEF_REG_W,
  parameter int SRC_W  = $clog2(NSRC),
  parameter int VEC_W  = DEF_VEC_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NSRC-1:0]   pend,
  input  logic [VEC_W-1:0]  vec,
  output logic [REG_W-1:0]  rdata,
  output logic [NSRC-1:0]   mask_q,
  output logic [NSRC-1:0]   force_q,
  output logic              prom_en,
  output logic [SRC_W-1:0]  prom_src
);
  localparam int NWORD = NSRC / REG_W;

  logic [REG_W-1:0] mask_w  [NWORD];
  logic [REG_W-1:0] force_w [NWORD];
  logic [REG_W-1:0] pend_w  [NWORD];

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    localparam logic [ADDR_W-1:0] MASK_A  = ADDR_W'(int'(A_MASK_LO) + w);
    localparam logic [ADDR_W-1:0] FORCE_A = ADDR_W'(int'(A_FORCE_LO) + w);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_w[w]  <= '0;
        force_w[w] <= '0;
      end else if (wr) begin
        if (addr == MASK_A)  mask_w[w]  <= wdata;
        if (addr == FORCE_A) force_w[w] <= wdata;
      end
    end

    assign mask_q[w*REG_W +: REG_W]  = mask_w[w];
    assign force_q[w*REG_W +: REG_W] = force_w[w];
    assign pend_w[w]                 = pend[w*REG_W +: REG_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prom_en  <= 1'b0;
      prom_src <= '0;
    end else if (wr && addr == ADDR_W'(A_PROMOTE)) begin
      prom_en  <= wdata[PROM_EN_BIT];
      prom_src <= wdata[SRC_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      A_VEC:      rdata = REG_W'(vec);
      A_PEND_LO:  rdata = pend_w[0];
      A_PEND_HI:  rdata = pend_w[NWORD-1];
      A_MASK_LO:  rdata = mask_w[0];
      A_MASK_HI:  rdata = mask_w[NWORD-1];
      A_FORCE_LO: rdata = force_w[0];
      A_FORCE_HI: rdata = force_w[NWORD-1];
      A_PROMOTE: begin
        rdata[PROM_EN_BIT]  = prom_en;
        rdata[SRC_W-1:0]    = prom_src;
      end
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/pve_level_gate.sv
module pve_level_gate #(
  parameter int NLVL  = pve_pkg::DEF_NLVL,
  parameter int NSRC  = pve_pkg::DEF_NSRC,
  parameter int SRC_W = $clog2(NSRC)
) (
  input  logic [NLVL-1:0]       lvl_en,
  input  logic [NLVL*SRC_W-1:0] lvl_src_flat,
  input  logic [NSRC-1:0]       active,
  output logic [SRC_W-1:0]      lvl_src [NLVL],
  output logic [NLVL-1:0]       hit
);
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign lvl_src[g] = lvl_src_flat[g*SRC_W +: SRC_W];
    assign hit[g]     = lvl_en[g] & active[lvl_src[g]];
  end
endmodule

// File: rtl/pve_first_hit.sv
module pve_first_hit #(
  parameter int N     = pve_pkg::DEF_NLVL,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     hit,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest index wins: scan from the top so the last match kept is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_vec_enc.sv
module prio_vec_enc
  import pve_pkg::*;
#(
  parameter int NSRC   = DEF_NSRC,
  parameter int NLVL   = DEF_NLVL,
  parameter int VEC_W  = DEF_VEC_W,
  parameter int REG_W  = DEF_REG_W,
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NSRC-1:0]                   src_req,
  input  logic [NLVL-1:0]                   lvl_en,
  input  logic [NLVL*$clog2(NSRC)-1:0]      lvl_src_flat,
  input  logic                              reg_wr,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic [REG_W-1:0]                  reg_wdata,
  output logic [REG_W-1:0]                  reg_rdata,
  output logic [VEC_W-1:0]                  vec_out,
  output logic                              irq
);
  localparam int SRC_W = $clog2(NSRC);
  localparam int LVL_W = $clog2(NLVL);

  logic [NSRC-1:0]  mask_q;
  logic [NSRC-1:0]  force_q;
  logic             prom_en;
  logic [SRC_W-1:0] prom_src;
  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  active;
  logic [SRC_W-1:0] lvl_src [NLVL];
  logic [NLVL-1:0]  hit;
  logic             lvl_found;
  logic [LVL_W-1:0] lvl_idx;
  logic             prom_hit;
  logic [SRC_W-1:0] win_src;
  logic [VEC_W-1:0] vec_d;
  logic [VEC_W-1:0] vec_q;
  logic             irq_q;

  assign pend   = src_req | force_q;
  assign active = pend & mask_q;

  pve_regs #(
    .NSRC(NSRC), .REG_W(REG_W), .SRC_W(SRC_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .pend(pend), .vec(vec_q), .rdata(reg_rdata), .mask_q(mask_q),
    .force_q(force_q), .prom_en(prom_en), .prom_src(prom_src)
  );

  pve_level_gate #(
    .NLVL(NLVL), .NSRC(NSRC), .SRC_W(SRC_W)
  ) u_gate (
    .lvl_en(lvl_en), .lvl_src_flat(lvl_src_flat), .active(active),
    .lvl_src(lvl_src), .hit(hit)
  );

  pve_first_hit #(
    .N(NLVL), .IDX_W(LVL_W)
  ) u_first (
    .hit(hit), .found(lvl_found), .idx(lvl_idx)
  );

  // promotion sits above level 0
  assign prom_hit = prom_en & active[prom_src];
  assign win_src  = prom_hit ? prom_src : lvl_src[lvl_idx];

  always_comb begin
    vec_d = '0;
    if (prom_hit || lvl_found) vec_d = VEC_W'(win_src) + VEC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      vec_q <= vec_d;
      irq_q <= prom_hit | lvl_found;
    end
  end

  assign vec_out = vec_q;
  assign irq     = irq_q;
endmodule

// File: rtl/prio_vec_enc_chk.sv
module prio_vec_enc_chk #(
  parameter int NSRC  = 64,
  parameter int VEC_W = 7,
  parameter int SRC_W = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VEC_W-1:0] vec_out,
  input logic             irq,
  input logic [NSRC-1:0]  active,
  input logic             prom_en,
  input logic [SRC_W-1:0] prom_src
);
  logic [NSRC-1:0] active_d;
  always_ff @(posedge clk) begin
    if (!rst_n) active_d <= '0;
    else        active_d <= active;
  end

  // R9
  irq_tracks_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec_out != '0));

  // R6
  vec_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_out <= VEC_W'(NSRC));

  // R3
  winner_was_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_out != '0 && vec_out <= VEC_W'(NSRC)) |-> active_d[SRC_W'(vec_out - VEC_W'(1))]);

  // R7
  promote_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prom_en && active[prom_src]) |=> (vec_out == VEC_W'($past(prom_src)) + VEC_W'(1)));

  // R8
  idle_gives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |=> (vec_out == '0));
endmodule

bind prio_vec_enc prio_vec_enc_chk #(
  .NSRC(NSRC), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_out(vec_out), .irq(irq),
  .active(active), .prom_en(prom_en), .prom_src(prom_src)
);

// File: tb/prio_vec_enc_tb.sv
module prio_vec_enc_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [63:0]  src_req = '0;
  logic [127:0] lvl_en = '0;
  logic [767:0] lvl_src_flat = '0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [6:0]   vec_out;
  logic         irq;

  prio_vec_enc u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .lvl_en(lvl_en),
    .lvl_src_flat(lvl_src_flat), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_out(vec_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R1";

  // stimulus staged for the next negedge
  logic [63:0]  nx_req = '0;
  logic [127:0] nx_en = '0;
  logic [5:0]   nx_src [128];

  // model of software-visible state
  logic [63:0] m_mask = '0;
  logic [63:0] m_force = '0;
  logic        m_prom_en = 1'b0;
  logic [5:0]  m_prom_src = '0;
  logic [6:0]  exp_vec = '0;
  logic [6:0]  cur_vec = '0;

  function automatic logic [6:0] model_vec();
    logic [63:0] act;
    act = (nx_req | m_force) & m_mask;
    if (m_prom_en && act[m_prom_src]) return 7'(m_prom_src) + 7'd1;
    for (int l = 0; l < 128; l++)
      if (nx_en[l] && act[nx_src[l]]) return 7'(nx_src[l]) + 7'd1;
    return 7'd0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] wd);
    @(negedge clk);
    check(vec_out == exp_vec, tag, 32'(vec_out), 32'(exp_vec));
    check(irq == (exp_vec != 0), "R9", 32'(irq), 32'(exp_vec != 0));
    cur_vec = exp_vec;
    src_req = nx_req;
    lvl_en  = nx_en;
    for (int l = 0; l < 128; l++) lvl_src_flat[l*6 +: 6] = nx_src[l];
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    exp_vec = rst_n ? model_vec() : 7'd0;
    if (wr && rst_n) begin
      case (a)
        3'd3: m_mask[31:0]   = wd;
        3'd4: m_mask[63:32]  = wd;
        3'd5: m_force[31:0]  = wd;
        3'd6: m_force[63:32] = wd;
        3'd7: begin m_prom_en = wd[7]; m_prom_src = wd[5:0]; end
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input bit use_vec, input string req);
    step(1'b0, a, 32'd0);
    #1;
    if (use_vec) check(reg_rdata == {25'd0, cur_vec}, req, reg_rdata, {25'd0, cur_vec});
    else         check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0);
  endtask

  task automatic lit(input logic [6:0] v, input string req);
    idle(2);
    check(vec_out == v, req, 32'(vec_out), 32'(v));
  endtask

  initial begin
    for (int l = 0; l < 128; l++) nx_src[l] = 6'(l % 64);
    tag = "R1";
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1 reset contents
    rd(3'd3, 32'd0, 0, "R1");
    rd(3'd4, 32'd0, 0, "R1");
    rd(3'd5, 32'd0, 0, "R1");
    rd(3'd7, 32'd0, 0, "R1");
    lit(7'd0, "R1");

    // R2 pending word
    tag = "R2";
    nx_req = 64'h0000_0100_8000_0001;
    rd(3'd1, 32'h8000_0001, 0, "R2");
    rd(3'd2, 32'h0000_0100, 0, "R2");

    // R3 masked requests stay silent, then unmask
    tag = "R3";
    nx_en = '1;
    nx_req = 64'h80;
    lit(7'd0, "R3");
    step(1'b1, 3'd3, 32'hFFFF_FFFF);
    step(1'b1, 3'd4, 32'hFFFF_FFFF);
    lit(7'd8, "R3");
    rd(3'd4, 32'hFFFF_FFFF, 0, "R3");

    // R4 force acts like a raw request
    tag = "R4";
    nx_req = '0;
    lit(7'd0, "R4");
    step(1'b1, 3'd5, 32'h20);
    lit(7'd6, "R4");
    rd(3'd1, 32'h20, 0, "R4");
    step(1'b1, 3'd6, 32'h4);
    lit(7'd6, "R4");
    step(1'b1, 3'd5, 32'h0);
    lit(7'd35, "R4");
    step(1'b1, 3'd6, 32'h0);
    lit(7'd0, "R4");

    // R5 lowest enabled level wins, disabled levels ignored
    tag = "R5";
    nx_req = 64'h408;
    lit(7'd4, "R5");
    nx_en[3] = 1'b0; nx_en[67] = 1'b0;
    lit(7'd11, "R5");
    nx_en = '1;

    // R6 vector follows the source, not the level
    tag = "R6";
    nx_req = 64'h0000_0100_0000_0008;
    nx_src[0] = 6'd40;
    lit(7'd41, "R6");
    nx_src[0] = 6'd0; nx_src[40] = 6'd0; nx_src[2] = 6'd40;
    lit(7'd41, "R6");
    nx_src[2] = 6'd2; nx_src[40] = 6'd40;
    lit(7'd4, "R6");

    // R7 promotion
    tag = "R7";
    nx_req = 64'h0004_0000_0000_0008;
    step(1'b1, 3'd7, 32'h80 | 32'd50);
    lit(7'd51, "R7");
    rd(3'd7, 32'hB2, 0, "R7");
    step(1'b1, 3'd4, 32'hFFFB_FFFF);
    lit(7'd4, "R7");
    step(1'b1, 3'd4, 32'hFFFF_FFFF);
    lit(7'd51, "R7");
    step(1'b1, 3'd7, 32'd50);
    lit(7'd4, "R7");

    // R10 vector register is read-only
    tag = "R10";
    step(1'b1, 3'd0, 32'hFFFF_FFFF);
    lit(7'd4, "R10");
    rd(3'd0, 32'd0, 1, "R10");
    rd(3'd3, 32'hFFFF_FFFF, 0, "R10");

    // R8 random traffic compared each clock
    tag = "R8";
    for (int i = 0; i < 2000; i++) begin
      nx_req = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      nx_en = ~({$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom});
      if ($urandom_range(0, 7) == 0)
        for (int l = 0; l < 128; l++) nx_src[l] = 6'($urandom);
      if ($urandom_range(0, 3) == 0)
        step(1'b1, 3'($urandom_range(0, 7)), $urandom & $urandom);
      else
        step(1'b0, 3'd0, 32'd0);
    end
    idle(2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule